// File: doc/BRIEF.md
# Thread-Offset Adaptive Load Prefetcher

This block sits beside the data cache of a SIMT core and watches the load misses that individual threads report. Within one warp, neighbouring threads of a single load instruction usually touch addresses a constant distance apart. The block learns that per-thread spacing for each load instruction and uses it to predict the line that a thread several warps ahead will need. Each predicted line address is handed to a prefetch queue.

The block keeps a small fully associative table keyed by the load's program counter. An entry remembers the last address and thread index seen, the learned per-thread offset, a 2-bit confidence counter, a prefetch distance counted in warps, and a 2-bit timeliness state. The timeliness state tracks whether the last prefetch is still in flight, has returned, or has been consumed. It steers the distance: a load that overtakes its prefetch makes the block look further ahead. A prefetched line that is still missed when used makes it look closer.

Two feedback inputs report prefetch data returning from memory and a cache miss on a line that had been prefetched. The cache, the memory system and the scheduler are outside the block.

Top module: `warp_offset_prefetcher`

## Requirements
- R1: After reset `pf_valid` is low, the table holds no entries, and the first miss of any PC produces no prefetch.
- R2: A miss whose PC matches no entry writes a new entry into the slot named by a round-robin pointer (slots 0..N_ENT-1, wrapping), evicting the previous owner. The new entry has offset 0, confidence 0, distance 1 and state load-seen (00). No two entries ever match the same PC.
- R3: On a miss to a known PC, step = tid − stored tid and delta = addr − stored addr, both two's complement. The miss matches when step ≠ 0 and delta equals offset × step modulo 2^ADDR_W. A match increments confidence, saturating at 3. A mismatch decrements it, saturating at 0, and replaces the offset with the low OFF_W bits of delta. The stored address and tid always take the new values.
- R4: A prefetch is produced only on a matching miss whose updated confidence exceeds CONF_THR (default 1). Its address is addr + offset × distance × 2^WARP_LG with the low LINE_LG bits cleared. It appears on `pf_addr` with `pf_valid` high after the clock edge that samples the miss.
- R5: State encoding: 00 load seen, 01 prefetch sent, 10 prefetch data returned. A miss that produces an accepted prefetch leaves the entry in 01; any other miss to a known PC leaves it in 00.
- R6: `ret_valid` with a PC whose entry is in 01 moves the entry to 10. A return for an unknown PC, or for an entry in any other state, has no effect.
- R7: A miss that finds its entry in 01 raises the distance by one, saturating at 2^DIST_W − 1 (7). The raised distance is used for that miss's prefetch address.
- R8: `early_valid` with a PC whose entry is in 10 lowers the distance by one, not below 1, and returns the entry to 00. In any other state it has no effect.
- R9: When a return or an early-miss report and a load miss address the same entry in one cycle, the report is applied first. A miss arriving with the return of its entry's prefetch therefore does not raise the distance.
- R10: While `pf_valid` is high and `pf_ready` is low, `pf_valid` and `pf_addr` hold. A prefetch produced in such a cycle is discarded, and its entry ends in state 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | A thread's load missed this cycle |
| miss_pc | input | PC_W | Program counter of the missing load |
| miss_tid | input | TID_W | Thread index of the missing thread |
| miss_addr | input | ADDR_W | Byte address that missed |
| ret_valid | input | 1 | Prefetched data returned from memory |
| ret_pc | input | PC_W | Load PC that owns the returned prefetch |
| early_valid | input | 1 | A line that had been prefetched still missed |
| early_pc | input | PC_W | Load PC that owns that line |
| pf_valid | output | 1 | Prefetch request present |
| pf_ready | input | 1 | Prefetch queue accepts the request |
| pf_addr | output | ADDR_W | Line-aligned prefetch address |

## Verification
The delicate case is a timeliness report and a load miss that land on the same entry in the same clock cycle. A return that coincides with the next miss must count as timely, and an early-miss report that coincides with a miss must lower the distance before the miss computes its address. The bench drives both pairings, and also a return on a different PC alongside a miss, at cycles chosen so that the entry is known to be in the sent or returned state. It judges the outcome from the distance encoded in that miss's prefetch address and in the address of the miss after it, against an arithmetic model of the requirements.

// File: rtl/fop_pkg.sv
package fop_pkg;

   // Timeliness state; the numeric codes are part of the interface contract.
   typedef enum logic [1:0] {
      PF_SEEN = 2'b00,
      PF_SENT = 2'b01,
      PF_RCVD = 2'b10
   } pf_state_e;

   localparam int CONF_W   = 2;
   localparam int CONF_MAX = (1 << CONF_W) - 1;

endpackage

// File: rtl/fop_entry.sv
module fop_entry
   import fop_pkg::*;
#(
   parameter int PC_W   = 32,
   parameter int ADDR_W = 32,
   parameter int TID_W  = 10,
   parameter int OFF_W  = 16,
   parameter int DIST_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PC_W-1:0]   miss_pc,
   input  logic              ret_valid,
   input  logic [PC_W-1:0]   ret_pc,
   input  logic              early_valid,
   input  logic [PC_W-1:0]   early_pc,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [TID_W-1:0]  wr_tid,
   input  logic [OFF_W-1:0]  wr_off,
   input  logic [CONF_W-1:0] wr_conf,
   input  logic [DIST_W-1:0] wr_dist,
   input  pf_state_e         wr_state,
   output logic              o_hit,
   output logic [ADDR_W-1:0] o_addr,
   output logic [TID_W-1:0]  o_tid,
   output logic [OFF_W-1:0]  o_off,
   output logic [CONF_W-1:0] o_conf,
   output logic [DIST_W-1:0] o_dist,
   output pf_state_e         o_state
);

   localparam logic [DIST_W-1:0] DIST_ONE = DIST_W'(1);

   logic              vld_q;
   logic [PC_W-1:0]   pc_q;
   logic [ADDR_W-1:0] addr_q;
   logic [TID_W-1:0]  tid_q;
   logic [OFF_W-1:0]  off_q;
   logic [CONF_W-1:0] conf_q;
   logic [DIST_W-1:0] dist_q;
   pf_state_e         st_q;

   logic      ret_hit, early_hit, early_apply;
   pf_state_e st_after_ret;
   pf_state_e st_view;
   logic [DIST_W-1:0] dist_view;

   assign o_hit     = vld_q && (pc_q == miss_pc);
   assign ret_hit   = ret_valid && vld_q && (pc_q == ret_pc);
   assign early_hit = early_valid && vld_q && (pc_q == early_pc);

   // Feedback is folded into the visible state before any miss uses it.
   always_comb begin
      st_after_ret = (ret_hit && st_q == PF_SENT) ? PF_RCVD : st_q;
      early_apply  = early_hit && (st_after_ret == PF_RCVD);
      st_view      = early_apply ? PF_SEEN : st_after_ret;
      if (early_apply && dist_q > DIST_ONE)
         dist_view = dist_q - DIST_ONE;
      else
         dist_view = dist_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         pc_q   <= '0;
         addr_q <= '0;
         tid_q  <= '0;
         off_q  <= '0;
         conf_q <= '0;
         dist_q <= DIST_ONE;
         st_q   <= PF_SEEN;
      end else if (wr_en) begin
         vld_q  <= 1'b1;
         pc_q   <= miss_pc;
         addr_q <= wr_addr;
         tid_q  <= wr_tid;
         off_q  <= wr_off;
         conf_q <= wr_conf;
         dist_q <= wr_dist;
         st_q   <= wr_state;
      end else begin
         dist_q <= dist_view;
         st_q   <= st_view;
      end
   end

   assign o_addr  = addr_q;
   assign o_tid   = tid_q;
   assign o_off   = off_q;
   assign o_conf  = conf_q;
   assign o_dist  = dist_view;
   assign o_state = st_view;

   // R7
   dist_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |-> (dist_q != '0));

   // R5
   state_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_q != 2'b11);

   // R6
   ret_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_hit && st_q == PF_SENT && !early_hit && !wr_en) |=> (st_q == PF_RCVD));

   // R8
   early_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (early_hit && st_q == PF_RCVD && !wr_en) |=> (st_q == PF_SEEN && dist_q != '0));

endmodule

// File: rtl/fop_train.sv
module fop_train
   import fop_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int TID_W    = 10,
   parameter int OFF_W    = 16,
   parameter int DIST_W   = 3,
   parameter int WARP_LG  = 5,
   parameter int LINE_LG  = 5,
   parameter int CONF_THR = 1
) (
   input  logic              miss_valid,
   input  logic              tbl_hit,
   input  logic [TID_W-1:0]  miss_tid,
   input  logic [ADDR_W-1:0] miss_addr,
   input  logic [ADDR_W-1:0] v_addr,
   input  logic [TID_W-1:0]  v_tid,
   input  logic [OFF_W-1:0]  v_off,
   input  logic [CONF_W-1:0] v_conf,
   input  logic [DIST_W-1:0] v_dist,
   input  pf_state_e         v_state,
   input  logic              slot_free,
   output logic [OFF_W-1:0]  n_off,
   output logic [CONF_W-1:0] n_conf,
   output logic [DIST_W-1:0] n_dist,
   output pf_state_e         n_state,
   output logic              issue,
   output logic [ADDR_W-1:0] issue_addr
);

   localparam logic [DIST_W-1:0] DIST_TOP  = DIST_W'((1 << DIST_W) - 1);
   localparam logic [DIST_W-1:0] DIST_INIT = DIST_W'(1);
   localparam logic [CONF_W-1:0] CONF_SAT  = CONF_W'(CONF_MAX);
   localparam logic [CONF_W-1:0] CONF_LIM  = CONF_W'(CONF_THR);
   localparam logic [ADDR_W-1:0] LINE_MASK =
      ~((ADDR_W'(1) << LINE_LG) - ADDR_W'(1));

   logic [TID_W:0]    step;
   logic [ADDR_W-1:0] step_ext, off_old_ext, off_new_ext, dist_ext;
   logic [ADDR_W-1:0] delta, expect_delta, span, raw_addr;
   logic              match;

   always_comb begin
      step         = {1'b0, miss_tid} - {1'b0, v_tid};
      step_ext     = {{(ADDR_W-TID_W-1){step[TID_W]}}, step};
      off_old_ext  = {{(ADDR_W-OFF_W){v_off[OFF_W-1]}}, v_off};
      delta        = miss_addr - v_addr;
      expect_delta = off_old_ext * step_ext;
      match        = tbl_hit && (step != '0) && (delta == expect_delta);

      if (!tbl_hit) begin
         n_off  = '0;
         n_conf = '0;
         n_dist = DIST_INIT;
      end else begin
         n_off  = match ? v_off : delta[OFF_W-1:0];
         if (match)
            n_conf = (v_conf == CONF_SAT) ? v_conf : v_conf + CONF_W'(1);
         else
            n_conf = (v_conf == '0) ? v_conf : v_conf - CONF_W'(1);
         if (v_state == PF_SENT && v_dist != DIST_TOP)
            n_dist = v_dist + DIST_W'(1);
         else
            n_dist = v_dist;
      end

      off_new_ext = {{(ADDR_W-OFF_W){n_off[OFF_W-1]}}, n_off};
      dist_ext    = {{(ADDR_W-DIST_W){1'b0}}, n_dist};
      span        = off_new_ext * dist_ext;
      raw_addr    = miss_addr + (span << WARP_LG);
      issue_addr  = raw_addr & LINE_MASK;

      issue   = miss_valid && match && (n_conf > CONF_LIM) && slot_free;
      n_state = issue ? PF_SENT : PF_SEEN;
   end

endmodule

// File: rtl/fop_out.sv
module fop_out #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic [ADDR_W-1:0] issue_addr,
   input  logic              pf_ready,
   output logic              slot_free,
   output logic              pf_valid,
   output logic [ADDR_W-1:0] pf_addr
);

   assign slot_free = !pf_valid || pf_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pf_valid <= 1'b0;
         pf_addr  <= '0;
      end else if (issue) begin
         pf_valid <= 1'b1;
         pf_addr  <= issue_addr;
      end else if (pf_ready) begin
         pf_valid <= 1'b0;
      end
   end

   // R10
   pf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr)));

   // R4
   issue_only_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue |-> slot_free);

endmodule

// File: rtl/warp_offset_prefetcher.sv
module warp_offset_prefetcher
   import fop_pkg::*;
#(
   parameter int N_ENT    = 32,
   parameter int PC_W     = 32,
   parameter int ADDR_W   = 32,
   parameter int TID_W    = 10,
   parameter int OFF_W    = 16,
   parameter int DIST_W   = 3,
   parameter int WARP_LG  = 5,
   parameter int LINE_LG  = 5,
   parameter int CONF_THR = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              miss_valid,
   input  logic [PC_W-1:0]   miss_pc,
   input  logic [TID_W-1:0]  miss_tid,
   input  logic [ADDR_W-1:0] miss_addr,
   input  logic              ret_valid,
   input  logic [PC_W-1:0]   ret_pc,
   input  logic              early_valid,
   input  logic [PC_W-1:0]   early_pc,
   output logic              pf_valid,
   input  logic              pf_ready,
   output logic [ADDR_W-1:0] pf_addr
);

   localparam int IDX_W = $clog2(N_ENT);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_ENT - 1);

   // Elaboration-time parameter checks
   if (N_ENT < 2) begin : g_bad_ent
      $error("N_ENT must be at least 2");
   end
   if (OFF_W < 2 || OFF_W >= ADDR_W) begin : g_bad_off
      $error("OFF_W must lie between 2 and ADDR_W-1");
   end
   if (TID_W + 1 >= ADDR_W) begin : g_bad_tid
      $error("TID_W must be at most ADDR_W-2");
   end
   if (DIST_W < 2 || DIST_W >= ADDR_W) begin : g_bad_dist
      $error("DIST_W must be at least 2");
   end
   if (CONF_THR < 0 || CONF_THR >= CONF_MAX) begin : g_bad_thr
      $error("CONF_THR must leave a reachable confidence above it");
   end
   if (LINE_LG < 0 || LINE_LG >= ADDR_W || WARP_LG < 0 || WARP_LG >= ADDR_W) begin : g_bad_shift
      $error("LINE_LG and WARP_LG must be below ADDR_W");
   end

   logic [N_ENT-1:0]  hit_v;
   logic [N_ENT-1:0]  wr_en;
   logic [ADDR_W-1:0] e_addr [N_ENT];
   logic [TID_W-1:0]  e_tid  [N_ENT];
   logic [OFF_W-1:0]  e_off  [N_ENT];
   logic [CONF_W-1:0] e_conf [N_ENT];
   logic [DIST_W-1:0] e_dist [N_ENT];
   pf_state_e         e_st   [N_ENT];

   logic              found;
   logic [IDX_W-1:0]  sel;
   logic [IDX_W-1:0]  rr_q;

   logic [OFF_W-1:0]  n_off;
   logic [CONF_W-1:0] n_conf;
   logic [DIST_W-1:0] n_dist;
   pf_state_e         n_state;
   logic              issue, slot_free;
   logic [ADDR_W-1:0] issue_addr;

   for (genvar i = 0; i < N_ENT; i++) begin : g_ent
      fop_entry #(
         .PC_W(PC_W), .ADDR_W(ADDR_W), .TID_W(TID_W),
         .OFF_W(OFF_W), .DIST_W(DIST_W)
      ) ent_i (
         .clk(clk), .rst_n(rst_n),
         .miss_pc(miss_pc),
         .ret_valid(ret_valid), .ret_pc(ret_pc),
         .early_valid(early_valid), .early_pc(early_pc),
         .wr_en(wr_en[i]),
         .wr_addr(miss_addr), .wr_tid(miss_tid), .wr_off(n_off),
         .wr_conf(n_conf), .wr_dist(n_dist), .wr_state(n_state),
         .o_hit(hit_v[i]),
         .o_addr(e_addr[i]), .o_tid(e_tid[i]), .o_off(e_off[i]),
         .o_conf(e_conf[i]), .o_dist(e_dist[i]), .o_state(e_st[i])
      );
      assign wr_en[i] = miss_valid && (found ? (sel == IDX_W'(i)) : (rr_q == IDX_W'(i)));
   end

   always_comb begin
      found = 1'b0;
      sel   = '0;
      for (int i = 0; i < N_ENT; i++) begin
         if (hit_v[i] && !found) begin
            found = 1'b1;
            sel   = IDX_W'(i);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rr_q <= '0;
      else if (miss_valid && !found)
         rr_q <= (rr_q == IDX_LAST) ? '0 : rr_q + IDX_W'(1);
   end

   fop_train #(
      .ADDR_W(ADDR_W), .TID_W(TID_W), .OFF_W(OFF_W), .DIST_W(DIST_W),
      .WARP_LG(WARP_LG), .LINE_LG(LINE_LG), .CONF_THR(CONF_THR)
   ) train_i (
      .miss_valid(miss_valid), .tbl_hit(found),
      .miss_tid(miss_tid), .miss_addr(miss_addr),
      .v_addr(e_addr[sel]), .v_tid(e_tid[sel]), .v_off(e_off[sel]),
      .v_conf(e_conf[sel]), .v_dist(e_dist[sel]), .v_state(e_st[sel]),
      .slot_free(slot_free),
      .n_off(n_off), .n_conf(n_conf), .n_dist(n_dist), .n_state(n_state),
      .issue(issue), .issue_addr(issue_addr)
   );

   fop_out #(.ADDR_W(ADDR_W)) out_i (
      .clk(clk), .rst_n(rst_n),
      .issue(issue), .issue_addr(issue_addr), .pf_ready(pf_ready),
      .slot_free(slot_free), .pf_valid(pf_valid), .pf_addr(pf_addr)
   );

   // R2
   one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_v));

   // R2
   rr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_valid && !found) |=> (rr_q != $past(rr_q)));

   if (LINE_LG > 0) begin : g_line_chk
      // R4
      pf_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
         pf_valid |-> (pf_addr[LINE_LG-1:0] == '0));
   end

endmodule

// File: tb/warp_offset_prefetcher_tb.sv
`timescale 1ns/1ps
module warp_offset_prefetcher_tb_top;

   localparam int ENT = 4;
   localparam int PW  = 16;
   localparam int AW  = 32;
   localparam int TW  = 8;
   localparam int OW  = 16;
   localparam int DW  = 3;
   localparam int WL  = 2;
   localparam int LL  = 5;
   localparam int THR = 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          miss_valid = 1'b0;
   logic [PW-1:0] miss_pc = '0;
   logic [TW-1:0] miss_tid = '0;
   logic [AW-1:0] miss_addr = '0;
   logic          ret_valid = 1'b0;
   logic [PW-1:0] ret_pc = '0;
   logic          early_valid = 1'b0;
   logic [PW-1:0] early_pc = '0;
   logic          pf_valid;
   logic          pf_ready = 1'b1;
   logic [AW-1:0] pf_addr;

   int  checks = 0;
   int  failures = 0;
   bit  done = 0;

   // Reference model state, built from the requirements
   bit            m_v    [ENT];
   logic [PW-1:0] m_pc   [ENT];
   logic [AW-1:0] m_addr [ENT];
   logic [TW-1:0] m_tid  [ENT];
   logic [OW-1:0] m_off  [ENT];
   int            m_conf [ENT];
   int            m_dist [ENT];
   int            m_st   [ENT];
   int            m_rr = 0;
   bit            m_pfv = 0;
   logic [AW-1:0] m_pfa = '0;

   always #10 clk = ~clk;

   warp_offset_prefetcher #(
      .N_ENT(ENT), .PC_W(PW), .ADDR_W(AW), .TID_W(TW), .OFF_W(OW),
      .DIST_W(DW), .WARP_LG(WL), .LINE_LG(LL), .CONF_THR(THR)
   ) dut_i (
      .clk(clk), .rst_n(rst_n),
      .miss_valid(miss_valid), .miss_pc(miss_pc), .miss_tid(miss_tid), .miss_addr(miss_addr),
      .ret_valid(ret_valid), .ret_pc(ret_pc),
      .early_valid(early_valid), .early_pc(early_pc),
      .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr)
   );

   task automatic chk(input bit ok, input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // One clock cycle: drive at the falling edge, predict, check at the next falling edge.
   task automatic cyc(input bit mv, input logic [PW-1:0] mpc, input logic [TW-1:0] mt,
                      input logic [AW-1:0] ma, input bit rv, input logic [PW-1:0] rpc,
                      input bit ev, input logic [PW-1:0] epc, input bit rdy, input string tag);
      bit slot_free, iss;
      int h, stp, o, c;
      logic [AW-1:0] delta, pa;
      miss_valid = mv; miss_pc = mpc; miss_tid = mt; miss_addr = ma;
      ret_valid = rv; ret_pc = rpc; early_valid = ev; early_pc = epc; pf_ready = rdy;

      slot_free = !m_pfv || rdy;
      iss = 0; pa = '0;
      for (int e = 0; e < ENT; e++) begin
         if (rv && m_v[e] && m_pc[e] == rpc && m_st[e] == 1) m_st[e] = 2;
         if (ev && m_v[e] && m_pc[e] == epc && m_st[e] == 2) begin
            if (m_dist[e] > 1) m_dist[e] = m_dist[e] - 1;
            m_st[e] = 0;
         end
      end
      if (mv) begin
         h = -1;
         for (int e = 0; e < ENT; e++) if (h < 0 && m_v[e] && m_pc[e] == mpc) h = e;
         if (h < 0) begin
            m_v[m_rr] = 1; m_pc[m_rr] = mpc; m_addr[m_rr] = ma; m_tid[m_rr] = mt;
            m_off[m_rr] = '0; m_conf[m_rr] = 0; m_dist[m_rr] = 1; m_st[m_rr] = 0;
            m_rr = (m_rr + 1) % ENT;
         end else begin
            stp = int'(mt) - int'(m_tid[h]);
            delta = ma - m_addr[h];
            o = $signed(m_off[h]);
            if (stp != 0 && delta == 32'(o * stp)) begin
               c = m_conf[h] + 1; if (c > 3) c = 3;
               m_conf[h] = c;
               if (m_st[h] == 1 && m_dist[h] < 7) m_dist[h] = m_dist[h] + 1;
               if (c > THR && slot_free) begin
                  iss = 1;
                  pa = ma + 32'(o * m_dist[h] * (1 << WL));
                  pa[LL-1:0] = '0;
               end
            end else begin
               c = m_conf[h] - 1; if (c < 0) c = 0;
               m_conf[h] = c;
               if (m_st[h] == 1 && m_dist[h] < 7) m_dist[h] = m_dist[h] + 1;
               m_off[h] = delta[OW-1:0];
            end
            m_st[h] = iss ? 1 : 0;
            m_addr[h] = ma; m_tid[h] = mt;
         end
      end
      if (iss) begin m_pfv = 1; m_pfa = pa; end
      else if (rdy) m_pfv = 0;

      @(posedge clk);
      @(negedge clk);
      chk(pf_valid == m_pfv, tag, {31'b0, pf_valid}, {31'b0, m_pfv});
      if (m_pfv) chk(pf_addr == m_pfa, tag, pf_addr, m_pfa);
   endtask

   task automatic miss(input logic [PW-1:0] pc, input logic [TW-1:0] t, input logic [AW-1:0] a, input string tag);
      cyc(1, pc, t, a, 0, '0, 0, '0, 1, tag);
   endtask

   task automatic idle(input bit rdy, input string tag);
      cyc(0, '0, '0, '0, 0, '0, 0, '0, rdy, tag);
   endtask

   function automatic logic [AW-1:0] adr(input logic [AW-1:0] base, input int off, input int t);
      return base + 32'(off * t);
   endfunction

   initial begin
      #(20 * 200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int offs [5] = '{4, -8, 36, 0, 1000};
      int steps [3] = '{1, 2, -1};
      logic [PW-1:0] p;
      logic [AW-1:0] b;
      int t;
      for (int e = 0; e < ENT; e++) m_v[e] = 0;

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state of the output
      chk(pf_valid == 1'b0, "R1", {31'b0, pf_valid}, 32'd0);
      idle(1, "R1");
      miss(16'd7, 8'd0, 32'h2000, "R1");

      // R3 R4 R7: sweep of offsets and thread steps; R2 eviction over 4 slots
      for (int oi = 0; oi < 5; oi++) begin
         for (int si = 0; si < 3; si++) begin
            p = 16'(100 + oi * 8 + si);
            b = 32'h0100_0000 + 32'(p) * 32'h1000;
            t = 20;
            for (int k = 0; k < 3; k++) begin
               miss(p, 8'(t), adr(b, offs[oi], t), "R3");
               t++;
            end
            t--;
            for (int k = 0; k < 4; k++) begin
               t += steps[si];
               miss(p, 8'(t), adr(b, offs[oi], t), "R4");
            end
         end
      end
      // R2: first swept PC has been evicted and must retrain without prefetching
      miss(16'd100, 8'd30, 32'h0106_4000, "R2");
      miss(16'd100, 8'd31, 32'h0106_4004, "R2");

      // R6 R8: timeliness feedback on a trained entry
      p = 16'd500; b = 32'h4000_0000;
      for (int k = 0; k < 4; k++) miss(p, 8'(k), adr(b, 64, k), "R5");
      cyc(0, '0, '0, '0, 1, p, 0, '0, 1, "R6");
      cyc(0, '0, '0, '0, 1, p, 0, '0, 1, "R6");
      cyc(0, '0, '0, '0, 0, '0, 1, p, 1, "R8");
      miss(p, 8'd4, adr(b, 64, 4), "R8");
      cyc(0, '0, '0, '0, 1, p, 0, '0, 1, "R6");
      miss(p, 8'd5, adr(b, 64, 5), "R6");
      miss(p, 8'd6, adr(b, 64, 6), "R7");
      miss(p, 8'd7, adr(b, 64, 7), "R7");
      cyc(0, '0, '0, '0, 1, 16'd999, 0, '0, 1, "R6");
      miss(p, 8'd8, adr(b, 64, 8), "R6");
      cyc(0, '0, '0, '0, 1, p, 0, '0, 1, "R6");
      cyc(0, '0, '0, '0, 0, '0, 1, p, 1, "R8");
      miss(p, 8'd9, adr(b, 64, 9), "R8");
      cyc(0, '0, '0, '0, 0, '0, 1, p, 1, "R8");
      miss(p, 8'd10, adr(b, 64, 10), "R8");

      // R9: feedback and miss on the same entry in the same cycle
      cyc(1, p, 8'd11, adr(b, 64, 11), 1, p, 0, '0, 1, "R9");
      cyc(1, p, 8'd12, adr(b, 64, 12), 1, p, 0, '0, 1, "R9");
      cyc(0, '0, '0, '0, 1, p, 0, '0, 1, "R9");
      cyc(1, p, 8'd13, adr(b, 64, 13), 0, '0, 1, p, 1, "R9");
      cyc(1, p, 8'd14, adr(b, 64, 14), 1, 16'd999, 0, '0, 1, "R9");

      // R7: distance saturates at 7
      for (int k = 15; k < 27; k++) miss(p, 8'(k), adr(b, 64, k), "R7");
      // R8: distance floors at 1
      for (int k = 0; k < 8; k++) begin
         cyc(0, '0, '0, '0, 1, p, 0, '0, 1, "R8");
         cyc(0, '0, '0, '0, 0, '0, 1, p, 1, "R8");
         miss(p, 8'(27 + k), adr(b, 64, 27 + k), "R8");
      end

      // R10: back-pressure holds the request and drops newer ones
      idle(1, "R10");
      cyc(1, p, 8'd40, adr(b, 64, 40), 0, '0, 0, '0, 0, "R10");
      cyc(1, p, 8'd41, adr(b, 64, 41), 0, '0, 0, '0, 0, "R10");
      cyc(1, p, 8'd42, adr(b, 64, 42), 0, '0, 0, '0, 0, "R10");
      idle(0, "R10");
      idle(1, "R10");
      miss(p, 8'd43, adr(b, 64, 43), "R5");
      miss(p, 8'd44, adr(b, 64, 44), "R5");
      idle(1, "R10");

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule